// File: doc/BRIEF.md
# Dual-Lane 8-bit SIMD Multiply-Add Unit

This unit is the arithmetic core of one processing element in a linear compute array. An opcode picks one of two operations. The multiply-add operation takes one signed 8-bit operand from each lane of two packed words, multiplies the pairs lane by lane, and adds each product into that lane's 24-bit partial sum from the accumulator word. The vector add operation sums two packed vectors of 24-bit partial sums lane by lane. Both operations share a single two-stage pipeline. The first stage selects and multiplies. The second stage adds. A new operation may enter on every cycle.

Every word is packed as two 24-bit lanes. Lane 0 sits in bits [23:0] and lane 1 in bits [47:24]. Lane sums wrap modulo 2^24, and no carry crosses from one lane into the next. Any opcode that is not one of the two arithmetic codes returns the accumulator word unchanged. The result register keeps its last value while no operation is in flight.

Top module: `simd_mac8_unit`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `out_valid` and `out_sum` are cleared to 0 at that edge, whatever the inputs are.
- R2: `out_valid` is high exactly 2 rising edges after an edge that samples `in_valid` high, and low 2 edges after an edge that samples it low. Operations issued on consecutive cycles come out on consecutive cycles, in order.
- R3: Opcode 2'b01 (multiply-add) gives, for each lane i, `in_acc` lane i plus the signed product of `in_x` bits [24i+7:24i] and `in_y` bits [24i+7:24i], sign-extended to 24 bits.
- R4: The multiply-add treats its 8-bit operands as two's complement. For example, -128 x -128 = 0x004000 and -128 x 127 = 0xFFC080.
- R5: In a multiply-add, bits [24i+23:24i+8] of `in_x` and `in_y` have no effect on the result.
- R6: Opcode 2'b10 (vector add) gives, for each lane i, `in_x` lane i plus `in_y` lane i. `in_acc` has no effect on the result.
- R7: Lane sums wrap modulo 2^24 and never saturate. A carry out of lane 0 does not change lane 1.
- R8: Opcodes 2'b00 and 2'b11 give a result equal to `in_acc`.
- R9: `out_sum` keeps its value on every cycle in which no result is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Marks the inputs of this cycle as an operation |
| in_opc | input | 2 | Operation code: 01 multiply-add, 10 vector add, others pass the accumulator |
| in_x | input | 48 | First packed operand word, two 24-bit lanes, lane 0 low |
| in_y | input | 48 | Second packed operand word, two 24-bit lanes, lane 0 low |
| in_acc | input | 48 | Packed accumulator word, two 24-bit lanes, lane 0 low |
| out_valid | output | 1 | The result word is new in this cycle |
| out_sum | output | 48 | Packed result word, two 24-bit lanes, lane 0 low |

## Verification
Each result comes due on the second rising edge after the edge that samples its inputs. That is one edge for the select-and-multiply register and one for the sum register. The bench drives inputs on falling edges and reads `out_valid` and `out_sum` on the falling edge two cycles after the drive, so each sample lands midway through the cycle in which its result is present. In the streaming scenario a new operation is issued on every falling edge. Each result is checked two falling edges after its issue. The bench then checks that `out_valid` drops one cycle after the last result and that `out_sum` holds across idle cycles.

// File: rtl/smac_pkg.sv
// Package: shared opcode encoding for the dual-lane multiply-add unit.
// Assumes a 2-bit opcode. Codes not listed here are decoded as pass-through.
package smac_pkg;

    typedef enum logic [1:0] {
        OPC_PASS  = 2'b00,
        OPC_MAC8  = 2'b01,
        OPC_ADD24 = 2'b10,
        OPC_SPARE = 2'b11
    } smac_opc_e;

endpackage

// File: rtl/smac_pipe_reg.sv
// Module: a pipeline register with a load enable and a synchronous active-low clear.
// Assumes the clear takes priority over the load enable.
module smac_pipe_reg #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    // Clear on reset, load when enabled, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (en) begin
            q <= d;
        end
    end

endmodule

// File: rtl/smac_lane_front.sv
// Module: first-stage logic of one lane. Decodes the opcode and produces the two
// terms that the second stage adds: a base term and an addend term.
//   multiply-add : base = accumulator lane, addend = sign-extended 8x8 product
//   vector add   : base = x lane,           addend = y lane
//   other codes  : base = accumulator lane, addend = 0
// Assumes ACCW >= 2*OPW, so the full product fits in the lane before it is summed.
module smac_lane_front
    import smac_pkg::*;
#(
    parameter int OPW  = 8,
    parameter int ACCW = 24
) (
    input  smac_opc_e        opc,
    input  logic [ACCW-1:0]  x_lane,
    input  logic [ACCW-1:0]  y_lane,
    input  logic [ACCW-1:0]  acc_lane,
    output logic [ACCW-1:0]  base,
    output logic [ACCW-1:0]  addend
);

    localparam int PW = 2 * OPW;

    logic signed [OPW-1:0] x_op;
    logic signed [OPW-1:0] y_op;
    logic signed [PW-1:0]  prod;
    logic signed [ACCW-1:0] prod_ext;

    // Take the low operand byte of each lane and form the signed product.
    always_comb begin
        x_op     = x_lane[OPW-1:0];
        y_op     = y_lane[OPW-1:0];
        prod     = x_op * y_op;
        prod_ext = ACCW'(prod);
    end

    // Pick the base and addend terms by opcode.
    always_comb begin
        case (opc)
            OPC_MAC8: begin
                base   = acc_lane;
                addend = prod_ext;
            end
            OPC_ADD24: begin
                base   = x_lane;
                addend = y_lane;
            end
            default: begin
                base   = acc_lane;
                addend = '0;
            end
        endcase
    end

endmodule

// File: rtl/simd_mac8_unit.sv
// Module: dual-lane 8-bit SIMD multiply-add and 24-bit vector add, two stages.
// Stage 1 registers the per-lane base and addend terms. Stage 2 registers their
// wrapped sum. A new operation can enter on every cycle, and its result appears
// two edges after entry. The data registers load only on valid, so the result
// holds between operations.
// Assumes the packed lane layout with lane 0 in the low bits, and ACCW >= 2*OPW.
module simd_mac8_unit
    import smac_pkg::*;
#(
    parameter int LANES = 2,
    parameter int OPW   = 8,
    parameter int ACCW  = 24
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic [1:0]            in_opc,
    input  logic [LANES*ACCW-1:0] in_x,
    input  logic [LANES*ACCW-1:0] in_y,
    input  logic [LANES*ACCW-1:0] in_acc,
    output logic                  out_valid,
    output logic [LANES*ACCW-1:0] out_sum
);

    localparam int TW = 2 * ACCW;

    smac_opc_e opc;
    logic      s1_valid;

    // Convert the raw opcode bits to the shared enum.
    always_comb begin
        opc = smac_opc_e'(in_opc);
    end

    // Carry the valid flag through both stages. It is cleared on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid  <= 1'b0;
            out_valid <= 1'b0;
        end else begin
            s1_valid  <= in_valid;
            out_valid <= s1_valid;
        end
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [ACCW-1:0] base;
        logic [ACCW-1:0] addend;
        logic [ACCW-1:0] base_q;
        logic [ACCW-1:0] addend_q;
        logic [ACCW-1:0] lane_sum;

        smac_lane_front #(
            .OPW  (OPW),
            .ACCW (ACCW)
        ) u_front (
            .opc      (opc),
            .x_lane   (in_x[g*ACCW +: ACCW]),
            .y_lane   (in_y[g*ACCW +: ACCW]),
            .acc_lane (in_acc[g*ACCW +: ACCW]),
            .base     (base),
            .addend   (addend)
        );

        smac_pipe_reg #(
            .W (TW)
        ) u_stage1 (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (in_valid),
            .d     ({base, addend}),
            .q     ({base_q, addend_q})
        );

        // Add within the lane width, so the sum wraps and nothing carries out.
        always_comb begin
            lane_sum = base_q + addend_q;
        end

        smac_pipe_reg #(
            .W (ACCW)
        ) u_stage2 (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (s1_valid),
            .d     (lane_sum),
            .q     (out_sum[g*ACCW +: ACCW])
        );
    end

endmodule

// File: rtl/simd_mac8_unit_chk.sv
// Module: assertion checker for simd_mac8_unit. It is attached with bind and only
// observes the top-level ports.
module simd_mac8_unit_chk #(
    parameter int LANES = 2,
    parameter int ACCW  = 24
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  in_valid,
    input logic [1:0]            in_opc,
    input logic [LANES*ACCW-1:0] in_x,
    input logic [LANES*ACCW-1:0] in_y,
    input logic [LANES*ACCW-1:0] in_acc,
    input logic                  out_valid,
    input logic [LANES*ACCW-1:0] out_sum
);

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && out_sum == '0));

    // R2
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> ##2 out_valid);

    // R2
    no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |-> ##2 !out_valid);

    // R6
    vec_add_lane0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_opc == 2'b10) |->
            ##2 (out_sum[ACCW-1:0] == $past(in_x[ACCW-1:0] + in_y[ACCW-1:0], 2)));

    // R8
    pass_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (in_opc == 2'b00 || in_opc == 2'b11)) |->
            ##2 (out_sum == $past(in_acc, 2)));

    // R9
    hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |-> ##2 $stable(out_sum));

endmodule

bind simd_mac8_unit simd_mac8_unit_chk #(
    .LANES (LANES),
    .ACCW  (ACCW)
) u_chk (.*);

// File: tb/simd_mac8_unit_tb.sv
module simd_mac8_unit_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [1:0]  in_opc;
    logic [47:0] in_x;
    logic [47:0] in_y;
    logic [47:0] in_acc;
    logic        out_valid;
    logic [47:0] out_sum;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    simd_mac8_unit u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_opc    (in_opc),
        .in_x      (in_x),
        .in_y      (in_y),
        .in_acc    (in_acc),
        .out_valid (out_valid),
        .out_sum   (out_sum)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Result model written from the requirements: each lane wraps at 24 bits.
    function automatic logic [47:0] expect_of(input logic [1:0] op, input logic [47:0] x,
                                              input logic [47:0] y, input logic [47:0] acc);
        logic [47:0] r;
        for (int l = 0; l < 2; l++) begin
            logic signed [7:0]  xs;
            logic signed [7:0]  ys;
            logic signed [15:0] p;
            xs = x[l*24 +: 8];
            ys = y[l*24 +: 8];
            p  = xs * ys;
            case (op)
                2'b01:   r[l*24 +: 24] = acc[l*24 +: 24] + {{8{p[15]}}, p};
                2'b10:   r[l*24 +: 24] = x[l*24 +: 24] + y[l*24 +: 24];
                default: r[l*24 +: 24] = acc[l*24 +: 24];
            endcase
        end
        return r;
    endfunction

    task automatic check(input string req, input logic [47:0] got, input logic [47:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got 0x%012h expected 0x%012h", req, got, exp);
        end
    endtask

    task automatic drive(input logic v, input logic [1:0] op, input logic [47:0] x,
                         input logic [47:0] y, input logic [47:0] acc);
        in_valid = v;
        in_opc   = op;
        in_x     = x;
        in_y     = y;
        in_acc   = acc;
    endtask

    // Issue one operation, then check it at the falling edge two cycles later.
    task automatic one_op(input string req, input logic [1:0] op, input logic [47:0] x,
                          input logic [47:0] y, input logic [47:0] acc,
                          input logic [47:0] exp);
        @(negedge clk);
        drive(1'b1, op, x, y, acc);
        @(negedge clk);
        drive(1'b0, 2'b00, '0, '0, '0);
        @(negedge clk);
        check({req, " valid"}, {47'd0, out_valid}, 48'd1);
        check(req, out_sum, exp);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        drive(1'b1, 2'b01, 48'h000003_000005, 48'h000007_000009, 48'h111111_222222);
        repeat (3) @(negedge clk);
        check("R1 valid", {47'd0, out_valid}, 48'd0);
        check("R1 sum", out_sum, 48'd0);
        drive(1'b0, 2'b00, '0, '0, '0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R1 idle after release", {47'd0, out_valid}, 48'd0);
    endtask

    task automatic t_mac_basic();
        logic [47:0] x = 48'h000011_000005;
        logic [47:0] y = 48'h000003_000007;
        logic [47:0] a = 48'h000100_000010;
        one_op("R3 mac basic", 2'b01, x, y, a, expect_of(2'b01, x, y, a));
        one_op("R3 mac literal", 2'b01, x, y, a, 48'h000133_000033);
    endtask

    task automatic t_mac_signed();
        one_op("R4 mac signed", 2'b01, 48'h000080_000080, 48'h00007F_000080, 48'd0,
               48'hFFC080_004000);
        one_op("R4 mac neg acc", 2'b01, 48'h0000FF_000002, 48'h000001_0000FD,
               48'h000000_000010, 48'hFFFFFF_00000A);
    endtask

    task automatic t_mac_upper();
        one_op("R5 mac upper bits ignored", 2'b01, 48'hABCD05_FFFF03, 48'h5A5A04_123402,
               48'h000001_000001, 48'h000015_000007);
    endtask

    task automatic t_vec_add();
        logic [47:0] x = 48'h123456_0ABCDE;
        logic [47:0] y = 48'h000111_100001;
        one_op("R6 vector add", 2'b10, x, y, 48'hFFFFFF_FFFFFF, 48'h123567_1ABCDF);
        one_op("R6 vector add model", 2'b10, y, x, 48'h0, expect_of(2'b10, y, x, 48'h0));
    endtask

    task automatic t_wrap();
        one_op("R7 add wrap no cross carry", 2'b10, 48'h7FFFFF_FFFFFF, 48'h000001_000001,
               48'd0, 48'h800000_000000);
        one_op("R7 mac wrap", 2'b01, 48'h000010_000010, 48'h000010_000010,
               48'hFFFF00_FFFF00, 48'h000000_000000);
    endtask

    task automatic t_pass();
        one_op("R8 opcode 00", 2'b00, 48'h000005_000005, 48'h000005_000005,
               48'hDEADBE_EF0123, 48'hDEADBE_EF0123);
        one_op("R8 opcode 11", 2'b11, 48'h000005_000005, 48'h000005_000005,
               48'h0F0F0F_F0F0F0, 48'h0F0F0F_F0F0F0);
    endtask

    // Back-to-back issue, then the valid drop and the hold during idle cycles.
    task automatic t_stream();
        logic [1:0]  ops [3] = '{2'b01, 2'b10, 2'b11};
        logic [47:0] xs  [3] = '{48'h0000FE_00007F, 48'h400000_3FFFFF, 48'h0};
        logic [47:0] ys  [3] = '{48'h000003_000002, 48'h400000_000001, 48'h0};
        logic [47:0] as  [3] = '{48'h000010_000020, 48'h0, 48'h00ABCD_00EF01};
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            if (i >= 2) begin
                check("R2 stream valid", {47'd0, out_valid}, 48'd1);
                check("R2 stream order", out_sum,
                      expect_of(ops[i-2], xs[i-2], ys[i-2], as[i-2]));
            end
            if (i < 3) drive(1'b1, ops[i], xs[i], ys[i], as[i]);
            else       drive(1'b0, 2'b01, 48'hFFFFFF_FFFFFF, 48'hFFFFFF_FFFFFF, 48'h1);
        end
        @(negedge clk);
        check("R2 valid drops", {47'd0, out_valid}, 48'd0);
        repeat (3) @(negedge clk);
        check("R9 hold while idle", out_sum, 48'h00ABCD_00EF01);
    endtask

    initial begin
        t_reset();
        t_mac_basic();
        t_mac_signed();
        t_mac_upper();
        t_vec_add();
        t_wrap();
        t_pass();
        t_stream();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule